// File: doc/BRIEF.md
# JTAG Debug Mailbox

This block is a two-way message box between a host debugger, which reaches it through JTAG scans, and a debug monitor on the local processor, which reaches it with ordinary register loads and stores. It holds an inbound 32-bit word, an outbound 32-bit word and a small control register with two full flags and a keep-awake bit. The host fills the inbound word and then raises the inbound flag, which interrupts the monitor. The monitor fills the outbound word and raises the outbound flag. The host scans the word out and clears that flag.

The TAP state machine and the instruction decoder are outside this block. They supply the register-select lines and the capture, shift and update strobes in the TCK domain. All storage lives in the system clock domain. Each scan-side update is carried across as a payload and a toggle, and the clock side detects the toggle after a synchroniser. Flag values go back to TCK through a synchroniser of their own, and a scan of the control register captures that synchronised copy. The bus side is a plain register port with one cycle of read latency. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `jtag_mailbox`

## Requirements
- R1: After reset the control word reads 0x00000004 (bit 0 outbound-full = 0, bit 1 inbound-full = 0, bit 2 keep-awake = 1), both data words read 0, and `irq` is low.
- R2: Bus word index 0 selects the inbound word, 1 the outbound word, 2 the control word and 3 nothing. A read returns the value on `bus_rdata` on the clock edge after the request. Control bits 31..3 and every bit of index 3 read 0, and writes to index 3 are dropped.
- R3: A bus write to the control word loads outbound-full, inbound-full and keep-awake directly from write-data bits 0, 1 and 2.
- R4: A scan of the inbound word captures its current value. After 32 shifts and an update, the shifted-in value is loaded into the inbound word, where the bus can read it.
- R5: A scan of the outbound word shifts out its contents, and an update with it selected leaves the word unchanged.
- R6: A scan-side control update with bit 0 = 1 clears outbound-full. With bit 0 = 0 the flag keeps its value.
- R7: A scan-side control update with bit 1 = 1 sets inbound-full and raises `irq` for exactly one system clock. With bit 1 = 0 the flag is kept and no interrupt fires. Every such update with bit 1 = 1 fires an interrupt, even when the flag is already set.
- R8: A scan-side control update loads keep-awake from bit 2. Capturing the control chain yields the synchronised flags in bits 2..0 and zeros in bits 7..3.
- R9: `pwr_down` is high exactly when `pd_req` is high and keep-awake is 0.
- R10: The scan chains shift least significant bit first. `tdo` presents bit 0 of the shift register, the data chains are 32 bits long and the control chain is 8 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | TCK-domain reset, active low |
| jt_sel_din | input | 1 | Inbound data chain selected |
| jt_sel_dout | input | 1 | Outbound data chain selected |
| jt_sel_ctrl | input | 1 | Control chain selected |
| jt_capture | input | 1 | Capture-DR strobe |
| jt_shift | input | 1 | Shift-DR strobe |
| jt_update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 2 | Bus word index |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, one cycle after request |
| pd_req | input | 1 | System power-down request |
| pwr_down | output | 1 | Block enters power-down |
| irq | output | 1 | One-cycle interrupt to the monitor |

## Verification
The bench goes after the asymmetric scan-side flag rules. A design that treated a scan 0 as a write would clear inbound-full or outbound-full by itself. One that treated a scan 1 on outbound-full as a set would leave it stuck at 1. A repeated inbound set must raise a second interrupt, so a design that fires only on a flag edge loses it. An interrupt held for more than one cycle shows up as an extra count. The outbound scan is checked for a destructive update that overwrites the word. The control capture is checked for stray upper bits and for a stale flag snapshot.

// File: rtl/jmb_pkg.sv
package jmb_pkg;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    REG_DIN  = 2'd0,
    REG_DOUT = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // bit 0 outbound-full, bit 1 inbound-full, bit 2 keep-awake
  typedef struct packed {
    logic keep_awake;
    logic in_full;
    logic out_full;
  } flags_t;

  localparam flags_t FLAGS_RST = '{keep_awake: 1'b1, in_full: 1'b0, out_full: 1'b0};
endpackage

// File: rtl/jmb_pulse_sync.sv
module jmb_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], tgl_in};
  end

  assign pulse = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/jmb_scan_side.sv
module jmb_scan_side
  import jmb_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              sel_din,
  input  logic              sel_dout,
  input  logic              sel_ctrl,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] din_sys,
  input  logic [DATA_W-1:0] dout_sys,
  input  flags_t            flags_sys,
  output logic              upd_tgl,
  output logic              upd_is_ctrl,
  output logic [DATA_W-1:0] upd_data,
  output flags_t            upd_flags
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  flags_t             fsync_q [SYNC_STAGES];
  logic [DATA_W-1:0]  sr_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) fsync_q[i] <= FLAGS_RST;
    end else begin
      fsync_q[0] <= flags_sys;
      for (int i = 1; i < SYNC_STAGES; i++) fsync_q[i] <= fsync_q[i-1];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (capture) begin
      if (sel_din)       sr_q <= din_sys;
      else if (sel_dout) sr_q <= dout_sys;
      else if (sel_ctrl) sr_q <= DATA_W'(fsync_q[LAST]);
    end else if (shift) begin
      if (sel_ctrl)                sr_q[CTRL_W-1:0] <= {tdi, sr_q[CTRL_W-1:1]};
      else if (sel_din || sel_dout) sr_q <= {tdi, sr_q[DATA_W-1:1]};
    end
  end

  assign tdo = sr_q[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_tgl     <= 1'b0;
      upd_is_ctrl <= 1'b0;
      upd_data    <= '0;
      upd_flags   <= FLAGS_RST;
    end else if (update && sel_din) begin
      upd_tgl     <= ~upd_tgl;
      upd_is_ctrl <= 1'b0;
      upd_data    <= sr_q;
    end else if (update && sel_ctrl) begin
      upd_tgl     <= ~upd_tgl;
      upd_is_ctrl <= 1'b1;
      upd_flags   <= flags_t'(sr_q[2:0]);
    end
  end
endmodule

// File: rtl/jmb_regfile.sv
module jmb_regfile
  import jmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              scan_evt,
  input  logic              upd_is_ctrl,
  input  logic [DATA_W-1:0] upd_data,
  input  flags_t            upd_flags,
  output logic [DATA_W-1:0] din_q,
  output logic [DATA_W-1:0] dout_q,
  output flags_t            flags_q,
  output logic              irq
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= '0;
      dout_q  <= '0;
      flags_q <= FLAGS_RST;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (bus_sel && bus_we) begin
        case (sel)
          REG_DIN:  din_q   <= bus_wdata;
          REG_DOUT: dout_q  <= bus_wdata;
          REG_CTRL: flags_q <= flags_t'(bus_wdata[2:0]);
          default:  ;
        endcase
      end
      // scan-side events take effect after any same-cycle bus write
      if (scan_evt) begin
        if (!upd_is_ctrl) begin
          din_q <= upd_data;
        end else begin
          if (upd_flags.out_full) flags_q.out_full <= 1'b0;
          if (upd_flags.in_full) begin
            flags_q.in_full <= 1'b1;
            irq             <= 1'b1;
          end
          flags_q.keep_awake <= upd_flags.keep_awake;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_we) begin
      case (sel)
        REG_DIN:  bus_rdata <= din_q;
        REG_DOUT: bus_rdata <= dout_q;
        REG_CTRL: bus_rdata <= DATA_W'(flags_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/jtag_mailbox.sv
module jtag_mailbox
  import jmb_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tck,
  input  logic              trst_n,
  input  logic              jt_sel_din,
  input  logic              jt_sel_dout,
  input  logic              jt_sel_ctrl,
  input  logic              jt_capture,
  input  logic              jt_shift,
  input  logic              jt_update,
  input  logic              tdi,
  output logic              tdo,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pd_req,
  output logic              pwr_down,
  output logic              irq
);
  logic [DATA_W-1:0] din_q, dout_q, upd_data;
  flags_t            flags_q, upd_flags;
  logic              upd_tgl, upd_is_ctrl, scan_evt;

  jmb_scan_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_scan (
    .tck(tck), .trst_n(trst_n),
    .sel_din(jt_sel_din), .sel_dout(jt_sel_dout), .sel_ctrl(jt_sel_ctrl),
    .capture(jt_capture), .shift(jt_shift), .update(jt_update),
    .tdi(tdi), .tdo(tdo),
    .din_sys(din_q), .dout_sys(dout_q), .flags_sys(flags_q),
    .upd_tgl(upd_tgl), .upd_is_ctrl(upd_is_ctrl),
    .upd_data(upd_data), .upd_flags(upd_flags)
  );

  jmb_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(upd_tgl), .pulse(scan_evt)
  );

  jmb_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scan_evt(scan_evt), .upd_is_ctrl(upd_is_ctrl),
    .upd_data(upd_data), .upd_flags(upd_flags),
    .din_q(din_q), .dout_q(dout_q), .flags_q(flags_q), .irq(irq)
  );

  assign pwr_down = pd_req && !flags_q.keep_awake;
endmodule

// File: rtl/jmb_checker.sv
module jmb_checker
  import jmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:3] rdata_hi,
  input logic              irq,
  input logic              pwr_down,
  input flags_t            flags,
  input logic [DATA_W-1:0] dout_q
);
  logic ctrl_wr, dout_wr, ctrl_rd;
  assign ctrl_wr = bus_sel && bus_we && (bus_addr == 2'd2);
  assign dout_wr = bus_sel && bus_we && (bus_addr == 2'd1);
  assign ctrl_rd = bus_sel && !bus_we && (bus_addr == 2'd2);

  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags.in_full);

  // R7
  in_full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.in_full && !ctrl_wr) |=> (!flags.in_full || irq));

  // R6
  out_full_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.out_full && !ctrl_wr) |=> !flags.out_full);

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_wr |=> $stable(dout_q));

  // R2
  ctrl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (rdata_hi == '0));

  // R9
  awake_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.keep_awake |-> !pwr_down);
endmodule

bind jtag_mailbox jmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .rdata_hi(bus_rdata[DATA_W-1:3]),
  .irq(irq), .pwr_down(pwr_down),
  .flags(flags_q), .dout_q(dout_q)
);

// File: tb/jtag_mailbox_bench.sv
module jtag_mailbox_bench;
  logic clk = 0, rst_n = 0, tck = 0, trst_n = 0;
  logic jt_sel_din = 0, jt_sel_dout = 0, jt_sel_ctrl = 0;
  logic jt_capture = 0, jt_shift = 0, jt_update = 0, tdi = 0;
  logic tdo;
  logic bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic pd_req = 0, pwr_down, irq;

  int total = 0, bad = 0, irq_cnt = 0;
  bit done = 0;

  always #4  clk = ~clk;
  always #20 tck = ~tck;

  jtag_mailbox u_jtag_mailbox (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
    .jt_sel_din(jt_sel_din), .jt_sel_dout(jt_sel_dout), .jt_sel_ctrl(jt_sel_ctrl),
    .jt_capture(jt_capture), .jt_shift(jt_shift), .jt_update(jt_update),
    .tdi(tdi), .tdo(tdo),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pd_req(pd_req), .pwr_down(pwr_down), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  typedef struct packed {
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expect_v;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'hA5A5_0001, 32'hA5A5_0001},
    '{2'd1, 32'h1234_5678, 32'h1234_5678},
    '{2'd2, 32'hFFFF_FFFA, 32'h0000_0002},
    '{2'd2, 32'h0000_0005, 32'h0000_0005},
    '{2'd3, 32'hDEAD_BEEF, 32'h0000_0000},
    '{2'd2, 32'h0000_0004, 32'h0000_0004}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // which: 0 inbound, 1 outbound, 2 control
  task automatic scan(input int which, input int len, input logic [31:0] din,
                      input bit upd, output logic [31:0] dout);
    dout = '0;
    repeat (4) @(negedge tck);
    jt_sel_din = (which == 0); jt_sel_dout = (which == 1); jt_sel_ctrl = (which == 2);
    jt_capture = 1;
    @(negedge tck);
    jt_capture = 0; jt_shift = 1;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(negedge tck);
    end
    jt_shift = 0;
    jt_update = upd;
    @(negedge tck);
    jt_update = 0; jt_sel_din = 0; jt_sel_dout = 0; jt_sel_ctrl = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, so;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1; trst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    bus_read(2'd2, r); chk("R1 ctrl", r, 32'h4);
    bus_read(2'd0, r); chk("R1 din", r, 32'h0);
    bus_read(2'd1, r); chk("R1 dout", r, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].addr, VECS[i].wdata);
      bus_read(VECS[i].addr, r);
      chk($sformatf("R2/R3 vec%0d", i), r, VECS[i].expect_v);
    end

    // R9 power-down gating
    pd_req = 1;
    @(negedge clk); chk("R9 awake", {31'd0, pwr_down}, 32'h0);
    bus_write(2'd2, 32'h0);
    @(negedge clk); chk("R9 asleep", {31'd0, pwr_down}, 32'h1);
    bus_write(2'd2, 32'h4);

    // R4 R10 inbound scan write then readback
    scan(0, 32, 32'hCAFE_F00D, 1, so);
    chk("R4 capture", so, 32'hA5A5_0001);
    bus_read(2'd0, r); chk("R4 bus sees scan", r, 32'hCAFE_F00D);
    scan(0, 32, 32'h0, 0, so);
    chk("R10 lsb-first", so, 32'hCAFE_F00D);

    // R5 outbound scan non-destructive
    bus_write(2'd1, 32'h8765_4321);
    scan(1, 32, 32'hFFFF_FFFF, 1, so);
    chk("R5 scan out", so, 32'h8765_4321);
    bus_read(2'd1, r); chk("R5 kept", r, 32'h8765_4321);

    // R6 R8 outbound-full rules
    bus_write(2'd2, 32'h5);
    scan(2, 8, 32'h04, 1, so);
    chk("R8 capture", so, 32'h05);
    bus_read(2'd2, r); chk("R6 zero keeps", r, 32'h5);
    scan(2, 8, 32'h05, 1, so);
    bus_read(2'd2, r); chk("R6 one clears", r, 32'h4);

    // R7 inbound-full and interrupt
    base = irq_cnt;
    scan(2, 8, 32'h04, 1, so);
    bus_read(2'd2, r); chk("R7 zero keeps", r, 32'h4);
    chk("R7 no irq", irq_cnt, base);
    scan(2, 8, 32'h06, 1, so);
    bus_read(2'd2, r); chk("R7 set", r, 32'h6);
    chk("R7 one pulse", irq_cnt, base + 1);
    scan(2, 8, 32'h06, 1, so);
    chk("R7 repeat irq", irq_cnt, base + 2);
    bus_write(2'd2, 32'h4);
    bus_read(2'd2, r); chk("R3 clear in_full", r, 32'h4);

    // R8 keep-awake from scan side
    scan(2, 8, 32'h00, 1, so);
    chk("R8 snapshot", so, 32'h04);
    bus_read(2'd2, r); chk("R8 keep-awake cleared", r, 32'h0);
    chk("R9 scan sleep", {31'd0, pwr_down}, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule